// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one active-low interrupt pin from outside the chip into an interrupt request for the CPU. The pin is brought into the clock domain by a short synchronizer chain. A falling edge on the synchronized pin sets a request latch. The latch holds its state until the CPU's vector-fetch acknowledge strobe clears it, software clears it, or reset clears it.

A small status and control register gives software four controls. A sensitivity bit adds a low-level trigger to the edge trigger. A mask bit blocks the request output to the CPU. A write-one acknowledge bit clears the latch from software. A read-only pending flag shows the request state whatever the mask setting, so software can poll the pin while the interrupt is masked.

In level mode, the request can only go inactive once two things have happened, in either order: an acknowledge, and the pin returning high. A new falling edge in the same cycle as an acknowledge wins, so that event is not lost.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a falling edge on `irq_pin_n`, the pending flag and (when unmasked) `irq_req` are high no later than three clock edges after the pin change. With MODE = 0 they stay high after the pin returns high, until an acknowledge arrives.
- R2: Software acknowledges by a write with bit 2 = 1, which clears the latch in the next cycle. A write with bit 2 = 0 leaves the latch unchanged, and bit 2 always reads 0.
- R3: After reset, MODE (bit 0) is 0 and only edges trigger. With MODE = 1, a low synchronized pin makes the pending flag high even when no edge has been seen.
- R4: With MODE = 0, a `vec_ack` pulse clears the request in the next cycle, even while the pin is still low.
- R5: With MODE = 1, the request stays high while the pin is low. It drops only after both an acknowledge and the pin's return high, and these may come in either order.
- R6: A trigger that arrives after an acknowledge sets the request again.
- R7: The pending flag (bit 3) shows the request state whatever the mask setting. With the mask clear, `irq_req` equals the pending flag.
- R8: While the mask bit (bit 1) is 1, `irq_req` is low, but edges are still latched and show up in the pending flag.
- R9: Reset clears the latch, MODE and the mask, so `irq_req` is low after reset even while the pin is held low.
- R10: A falling edge detected in the same cycle as an acknowledge leaves the latch set.
- R11: Register bits 0 (MODE) and 1 (mask) are read/write. Bit 3 is the read-only pending flag. Bit 2 and bits 7..4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| vec_ack | input | 1 | One-cycle vector-fetch acknowledge from the CPU |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value (bit 3 pending, bit 1 mask, bit 0 mode) |
| irq_req | output | 1 | Masked interrupt request to the CPU |

## Verification
The hardest case to reach from the ports is a new falling edge that is detected in the very cycle an acknowledge is sampled. The edge pulse appears two clock edges after the pin changes, so the bench first sets the latch and returns the pin high. It then drives the pin low and holds the `vec_ack` strobe back by exactly two cycles, so that both land on the same clock edge. The two orderings of level-mode release (acknowledge then pin high, and pin high then acknowledge) are each built up step by step in the vector table.

// File: rtl/ext_irq_pkg.sv
// Package: shared register width and control/status bit positions
// for the external interrupt pin controller.
package ext_irq_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_MODE = 0;   // level+edge sensitivity when 1
    localparam int BIT_MASK = 1;   // blocks request output when 1
    localparam int BIT_ACK  = 2;   // write-one acknowledge, reads 0
    localparam int BIT_PEND = 3;   // read-only pending flag
endpackage

// File: rtl/ext_irq_sync.sv
// Module: ext_irq_sync
// Brings the asynchronous pin into the clock domain through a shift
// chain of STAGES flops. Assumes STAGES >= 2. The chain resets to 0, so
// a pin already high or held low at reset release never reads as an edge.
module ext_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_async};
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge.sv
// Module: ext_irq_edge
// Produces a one-cycle pulse when the synchronized pin goes from high
// to low. Assumes its input is already synchronous to clk.
module ext_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    output logic fall
);
    logic prev_q;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_sync;
    end

    assign fall = prev_q & ~pin_sync;
endmodule

// File: rtl/ext_irq_latch.sv
// Module: ext_irq_latch
// Holds the edge-triggered request and combines it with the optional
// low-level term. A set beats a clear in the same cycle. The level term
// needs no acknowledge and simply follows the synchronized pin.
module ext_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic pin_low,
    input  logic level_en,
    input  logic clr,
    output logic pending
);
    logic latch_q;

    // Set on a detected edge, else clear on any acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    latch_q <= 1'b0;
        else if (fall) latch_q <= 1'b1;
        else if (clr)  latch_q <= 1'b0;
    end

    // Pending while latched, or while held low in level mode.
    always_comb begin
        pending = latch_q | (level_en & pin_low);
    end
endmodule

// File: rtl/ext_irq_regs.sv
// Module: ext_irq_regs
// Status/control register: MODE and mask storage, the write-one
// acknowledge decode, and read-back assembly. Assumes one write per cycle.
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pending,
    output logic         mode,
    output logic         mask,
    output logic         sw_ack,
    output logic [W-1:0] rd_data
);
    logic unused_wr_hi;

    // Store the mode and mask bits on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 1'b0;
            mask <= 1'b0;
        end else if (wr_en) begin
            mode <= wr_data[BIT_MODE];
            mask <= wr_data[BIT_MASK];
        end
    end

    // Decode the write-one acknowledge strobe.
    always_comb begin
        sw_ack = wr_en & wr_data[BIT_ACK];
    end

    // Assemble the read value; unlisted bits read zero.
    always_comb begin
        rd_data           = '0;
        rd_data[BIT_MODE] = mode;
        rd_data[BIT_MASK] = mask;
        rd_data[BIT_PEND] = pending;
    end

    assign unused_wr_hi = ^wr_data[W-1:BIT_PEND];
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: ext_irq_ctrl (top)
// External interrupt pin controller: synchronizer, falling-edge detect,
// request latch with optional level hold, and the status/control register.
// Assumes vec_ack is a one-cycle strobe from the CPU.
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int REG_W_P     = REG_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_pin_n,
    input  logic               vec_ack,
    input  logic               wr_en,
    input  logic [REG_W_P-1:0] wr_data,
    output logic [REG_W_P-1:0] rd_data,
    output logic               irq_req
);
    logic pin_sync;
    logic fall_pulse;
    logic pending;
    logic mode;
    logic mask;
    logic sw_ack;
    logic any_ack;

    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (irq_pin_n),
        .pin_sync  (pin_sync)
    );

    ext_irq_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .fall     (fall_pulse)
    );

    // Either acknowledge source clears the latch.
    always_comb begin
        any_ack = vec_ack | sw_ack;
    end

    ext_irq_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall     (fall_pulse),
        .pin_low  (~pin_sync),
        .level_en (mode),
        .clr      (any_ack),
        .pending  (pending)
    );

    ext_irq_regs #(.W(REG_W_P)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pending (pending),
        .mode    (mode),
        .mask    (mask),
        .sw_ack  (sw_ack),
        .rd_data (rd_data)
    );

    // Gate the request to the CPU with the mask bit.
    always_comb begin
        irq_req = pending & ~mask;
    end
endmodule

// File: rtl/ext_irq_chk.sv
// Module: ext_irq_chk
// Property checker bound into ext_irq_ctrl. It watches the ports plus the
// synchronized pin and edge pulse.
module ext_irq_chk
    import ext_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         vec_ack,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic         irq_req,
    input logic         fall,
    input logic         pin_s
);
    // R8
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_MASK] |-> !irq_req);

    // R7
    pend_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BIT_PEND] && !rd_data[BIT_MASK]) |-> irq_req);

    // R2
    sw_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_ACK] && !wr_data[BIT_MODE] && !fall) |=> !rd_data[BIT_PEND]);

    // R4
    vec_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !wr_en && !rd_data[BIT_MODE] && !fall) |=> !rd_data[BIT_PEND]);

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BIT_MODE] && !pin_s) |-> rd_data[BIT_PEND]);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> rd_data[BIT_PEND]);

    // R1
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BIT_PEND] && !rd_data[BIT_MODE] && !vec_ack && !wr_en) |=> rd_data[BIT_PEND]);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[W-1:BIT_PEND+1] == '0) && !rd_data[BIT_ACK]);
endmodule

bind ext_irq_ctrl ext_irq_chk #(.W(REG_W_P)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vec_ack (vec_ack),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_req (irq_req),
    .fall    (fall_pulse),
    .pin_s   (pin_sync)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic       vec_ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .vec_ack(vec_ack),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req)
    );

    // Vector: {pin, vec_ack, wr_en, wr_data[7:0], exp_req, exp_rd[7:0]}
    // Register read: bit3 pending, bit1 mask, bit0 mode.
    localparam int NV = 20;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00},  // R9 idle after reset
        {1'b0,1'b0,1'b0,8'h00, 1'b1,8'h08},  // R1 edge sets
        {1'b1,1'b0,1'b0,8'h00, 1'b1,8'h08},  // R1 held after pin high
        {1'b1,1'b0,1'b1,8'h00, 1'b1,8'h08},  // R2 ack bit 0 no effect
        {1'b1,1'b0,1'b1,8'h04, 1'b0,8'h00},  // R2 ack bit 1 clears
        {1'b0,1'b0,1'b0,8'h00, 1'b1,8'h08},  // R6 relatch after ack
        {1'b0,1'b1,1'b0,8'h00, 1'b0,8'h00},  // R4 vec ack, pin still low
        {1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00},  // R4 stays clear
        {1'b1,1'b0,1'b1,8'h02, 1'b0,8'h02},  // R11 mask write
        {1'b0,1'b0,1'b0,8'h00, 1'b0,8'h0A},  // R8 latched but masked
        {1'b1,1'b0,1'b1,8'h00, 1'b1,8'h08},  // R7 unmask shows request
        {1'b1,1'b0,1'b1,8'h05, 1'b0,8'h01},  // R2 ack + mode set
        {1'b0,1'b0,1'b0,8'h00, 1'b1,8'h09},  // R5 level mode edge
        {1'b0,1'b1,1'b0,8'h00, 1'b1,8'h09},  // R5 ack while low: held
        {1'b1,1'b0,1'b0,8'h00, 1'b0,8'h01},  // R5 pin high after ack
        {1'b0,1'b0,1'b0,8'h00, 1'b1,8'h09},  // R6 retrigger
        {1'b1,1'b0,1'b0,8'h00, 1'b1,8'h09},  // R5 pin high, no ack
        {1'b1,1'b1,1'b0,8'h00, 1'b0,8'h01},  // R5 ack after pin high
        {1'b1,1'b0,1'b1,8'h07, 1'b0,8'h03},  // R11 ack reads 0
        {1'b1,1'b0,1'b1,8'h01, 1'b0,8'h01}   // R11 mode only
    };
    localparam int TAG [NV] = '{9,1,1,2,2,6,4,4,11,8,7,2,5,5,5,6,5,5,11,11};

    task automatic check(input string req, input logic exp_req, input logic [7:0] exp_rd);
        n_checks++;
        if (irq_req !== exp_req || rd_data !== exp_rd) begin
            n_fail++;
            $display("FAIL %s: irq_req=%0b rd_data=%02h expected irq_req=%0b rd_data=%02h",
                     req, irq_req, rd_data, exp_req, exp_rd);
        end
    endtask

    // Apply one step: strobes last a cycle, then settle three cycles.
    task automatic step(input logic pin, input logic ack, input logic we, input logic [7:0] wd);
        @(negedge clk);
        irq_pin_n = pin; vec_ack = ack; wr_en = we; wr_data = wd;
        @(negedge clk);
        vec_ack = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 reset state", 1'b0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
            check($sformatf("R%0d vector %0d", TAG[i], i), VEC[i][8], VEC[i][7:0]);
        end

        // R3: level alone triggers once MODE is set (no new edge)
        step(1'b1, 1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b1, 1'b0, 8'h00);
        check("R3 edge-only after ack", 1'b0, 8'h00);
        step(1'b0, 1'b0, 1'b1, 8'h01);
        check("R3 level sensitivity", 1'b1, 8'h09);

        // R9: reset with the pin held low clears everything
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 reset with pin low", 1'b0, 8'h00);

        // R10: edge detected in the same cycle as vec_ack
        step(1'b1, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 1'b0, 8'h00);
        check("R10 latch set before race", 1'b1, 8'h08);
        @(negedge clk); irq_pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk); vec_ack = 1'b1;
        @(negedge clk); vec_ack = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 set beats ack", 1'b1, 8'h08);
        step(1'b0, 1'b1, 1'b0, 8'h00);
        check("R4 plain ack after race", 1'b0, 8'h00);

        // R11: all-ones write reads back only mode and mask
        step(1'b1, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 1'b1, 8'hFF);
        check("R11 reserved bits read 0", 1'b0, 8'h03);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule